// File: doc/BRIEF.md
# FIFO Transmit Interval Pacer

This block spaces out back-to-back frames sent from a transmit/receive FIFO. Each time the protocol engine reports that a frame has finished, the block loads a programmed interval into a down-counter. Once that counter has run out, it raises a one-cycle transmit request towards the FIFO. The arbitration logic and the protocol engine sit outside the block.

The counter steps on a selectable tick. The first choice is the wrap of a free-running prescaler that runs at half the system clock rate and reloads from a programmed value. The second is every tenth such wrap. The third is an externally supplied bit-time clock enable. The prescaler keeps running through frame completions, so the first step of an interval can come earlier than a full tick period.

Top module: `fifo_tx_pacer`

## Requirements
- R1: A one-cycle `tx_done` loads `ivl_val` and sets `busy` at the next edge. A `tx_done` that arrives while `busy` is high reloads the count and restarts it. A tick in the same cycle as `tx_done` is discarded.
- R2: While busy, each tick lowers the count by one. For an interval v of 1 or more, the request follows the v-th tick after loading, and earlier ticks raise no request.
- R3: An interval of 0 raises the request on the first tick after loading. It does not wrap to the maximum count.
- R4: `tx_req` is high for exactly one cycle, the cycle after the expiring tick. `busy` falls at the same edge. While idle, ticks raise no request and leave `busy` low.
- R5: The prescaler advances once every two system clocks. With a programmed value m it counts m-1 down to 0 and produces one tick per 2*m clocks. A value of 0 acts as 1.
- R6: A frame completion does not restart the prescaler. In tick-direct mode with v of 1 or more, the delay from the `tx_done` cycle to the `tx_req` cycle lies in [(v-1)*2m+2, v*2m+1]. The exact value depends on the phase of the prescaler.
- R7: `src_sel` 2'b00 uses every prescaler tick. 2'b10 uses every tenth prescaler tick, giving a period of 20*m clocks. Any value with bit 0 set uses `bit_clk_en` as the tick and ignores the prescaler.
- R8: Reset clears `tx_req` and `busy`, the prescaler and the divide-by-ten counter. The first prescaler tick falls in the second cycle after reset release, and the first divided tick follows the tenth prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk_en | input | 1 | One-cycle bit-time clock enable |
| presc_val | input | 16 | Prescaler reload value m |
| src_sel | input | 2 | Tick source and resolution select |
| ivl_val | input | 8 | Interval count, 0 to 255 |
| tx_done | input | 1 | One-cycle frame-complete pulse |
| tx_req | output | 1 | One-cycle FIFO transmit request |
| busy | output | 1 | Interval count in progress |

## Verification
The bench uses the default parameters: a 16-bit prescaler, an 8-bit interval and a divide-by-ten stage. It programs prescaler values of 0 to 3, which keeps tick periods between 2 and 40 clocks. Because the tick phase can be recovered from the previous request, the bench sweeps every phase offset of `tx_done` against the prescaler and predicts each delay exactly. In bit-clock mode, pulses driven by the bench reach the full 255-count interval, the zero interval, restarts and collisions one pulse at a time.

// File: rtl/fifo_pacer_pkg.sv
package fifo_pacer_pkg;

    // Tick source selection; bit 0 set picks the bit-time enable.
    typedef enum logic [1:0] {
        SRC_PRESC  = 2'b00,
        SRC_BIT_A  = 2'b01,
        SRC_DECADE = 2'b10,
        SRC_BIT_B  = 2'b11
    } src_sel_e;

    function automatic logic src_is_bit(input logic [1:0] sel);
        return sel[0];
    endfunction

endpackage

// File: rtl/pacer_prescaler.sv
module pacer_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] m_val,
    output logic             wrap
);

    typedef struct packed {
        logic             phase;
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] reload;

    always_comb begin
        st_d   = st_q;
        reload = (m_val == '0) ? '0 : m_val - PRE_W'(1);
        wrap   = st_q.phase && (st_q.cnt == '0);
        st_d.phase = ~st_q.phase;
        if (st_q.phase) begin
            st_d.cnt = wrap ? reload : st_q.cnt - PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: half-rate enable means two wraps never land on adjacent cycles
    p_half_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wrap);

    // R5: the counter only moves on enable cycles
    p_hold_off_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.phase |=> $stable(st_q.cnt));

endmodule

// File: rtl/pacer_tick_sel.sv
module pacer_tick_sel
    import fifo_pacer_pkg::*;
#(
    parameter int DEC_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pre_wrap,
    input  logic       bit_en,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int DEC_W = (DEC_DIV > 1) ? $clog2(DEC_DIV) : 1;

    logic dec_tick;

    generate
        if (DEC_DIV > 1) begin : g_decade
            typedef struct packed {
                logic [DEC_W-1:0] cnt;
            } dec_st_t;

            dec_st_t dec_d, dec_q;
            logic    dec_last;

            always_comb begin
                dec_d    = dec_q;
                dec_last = (dec_q.cnt == DEC_W'(DEC_DIV - 1));
                if (pre_wrap) begin
                    dec_d.cnt = dec_last ? '0 : dec_q.cnt + DEC_W'(1);
                end
            end

            assign dec_tick = pre_wrap && dec_last;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dec_q <= '0;
                end else begin
                    dec_q <= dec_d;
                end
            end

            // R7: divider never leaves its range
            p_dec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
                dec_q.cnt < DEC_W'(DEC_DIV));

            // R8: divider is clear straight after reset
            p_dec_reset_r8: assert property (@(posedge clk)
                !rst_n |=> dec_q.cnt == '0);
        end else begin : g_no_decade
            assign dec_tick = pre_wrap;
        end
    endgenerate

    always_comb begin
        if (src_is_bit(sel)) begin
            tick = bit_en;
        end else if (sel == SRC_DECADE) begin
            tick = dec_tick;
        end else begin
            tick = pre_wrap;
        end
    end

    // R7: a divided tick only ever coincides with a prescaler wrap
    p_dec_on_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_DECADE && tick) |-> pre_wrap);

endmodule

// File: rtl/pacer_interval.sv
module pacer_interval #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [IVL_W-1:0] ivl,
    output logic             req,
    output logic             busy
);

    typedef struct packed {
        logic             run;
        logic [IVL_W-1:0] cnt;
        logic             req;
    } ivl_st_t;

    ivl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (load) begin
            st_d.run = 1'b1;
            st_d.cnt = ivl;
        end else if (st_q.run && tick) begin
            if (st_q.cnt <= IVL_W'(1)) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - IVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign busy = st_q.run;

    // R1: a completion always leaves the timer running
    p_load_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R2: a request needs a running timer and a tick one cycle earlier
    p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(st_q.run && tick && !load));

    // R3: a zero count expires on the first tick
    p_zero_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !load && st_q.cnt == '0) |=> req);

    // R4: single-cycle request, and idle stays idle without a load
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> (!busy && !$rose(busy)));

endmodule

// File: rtl/fifo_tx_pacer.sv
module fifo_tx_pacer #(
    parameter int PRE_W   = 16,
    parameter int IVL_W   = 8,
    parameter int DEC_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk_en,
    input  logic [PRE_W-1:0] presc_val,
    input  logic [1:0]       src_sel,
    input  logic [IVL_W-1:0] ivl_val,
    input  logic             tx_done,
    output logic             tx_req,
    output logic             busy
);

    logic pre_wrap;
    logic tick;

    pacer_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .m_val (presc_val),
        .wrap  (pre_wrap)
    );

    pacer_tick_sel #(.DEC_DIV(DEC_DIV)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_wrap (pre_wrap),
        .bit_en   (bit_clk_en),
        .sel      (src_sel),
        .tick     (tick)
    );

    pacer_interval #(.IVL_W(IVL_W)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_done),
        .tick  (tick),
        .ivl   (ivl_val),
        .req   (tx_req),
        .busy  (busy)
    );

    // R4: request and busy are never high together
    p_req_excl_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (!busy || $past(tx_done)));

endmodule

// File: tb/sim_fifo_tx_pacer.sv
module sim_fifo_tx_pacer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk_en = 1'b0;
    logic [15:0] presc_val = 16'd3;
    logic [1:0]  src_sel = 2'b01;
    logic [7:0]  ivl_val = 8'd0;
    logic        tx_done = 1'b0;
    logic        tx_req;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    fifo_tx_pacer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_clk_en (bit_clk_en),
        .presc_val  (presc_val),
        .src_sel    (src_sel),
        .ivl_val    (ivl_val),
        .tx_done    (tx_done),
        .tx_req     (tx_req),
        .busy       (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic start(input int v);
        ivl_val = 8'(v);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic bit_pulse();
        bit_clk_en = 1'b1;
        @(negedge clk);
        bit_clk_en = 1'b0;
    endtask

    // mode 0: arrival only, 1: window, 2: exact phase-derived delay
    task automatic pre_trial(input int w, input int v, input int P, input int mode,
                             input string rq);
        int d;
        int vv;
        int first;
        int exp;
        bit seen;
        vv = (v == 0) ? 1 : v;
        repeat (w) @(negedge clk);
        ivl_val = 8'(v);
        tx_done = 1'b1;
        d = 0;
        seen = 1'b0;
        while (!seen && d < vv * P + 2 * P + 60) begin
            @(negedge clk);
            tx_done = 1'b0;
            d++;
            if (tx_req) seen = 1'b1;
            else if (d == 1) chk(busy == 1'b1, "R1", int'(busy), 1);
        end
        chk(seen, rq, int'(seen), 1);
        first = (P - 1 - w) % P;
        if (first == 0) first = P;
        exp = first + (vv - 1) * P + 1;
        if (mode == 2) chk(d == exp, rq, d, exp);
        else if (mode == 1) chk(d >= (vv - 1) * P + 2 && d <= vv * P + 1, rq, d, vv * P + 1);
        chk(busy == 1'b0, "R4", int'(busy), 0);
    endtask

    initial begin
        int hits;
        int d;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk(tx_req == 1'b0, "R8", int'(tx_req), 0);
        chk(busy == 1'b0, "R8", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: bit-clock mode, interval 3, tick colliding with load is dropped
        src_sel = 2'b01;
        ivl_val = 8'd3;
        tx_done = 1'b1;
        bit_clk_en = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        bit_clk_en = 1'b0;
        chk(busy == 1'b1, "R1", int'(busy), 1);
        bit_pulse(); chk(tx_req == 1'b0, "R2", int'(tx_req), 0);
        @(negedge clk);
        bit_pulse(); chk(tx_req == 1'b0, "R2", int'(tx_req), 0);
        chk(busy == 1'b1, "R2", int'(busy), 1);
        @(negedge clk);
        bit_pulse();
        chk(tx_req == 1'b1, "R2", int'(tx_req), 1);
        chk(busy == 1'b0, "R4", int'(busy), 0);
        @(negedge clk);
        chk(tx_req == 1'b0, "R4", int'(tx_req), 0);

        // R4: ticks while idle do nothing
        hits = 0;
        for (int i = 0; i < 5; i++) begin
            bit_pulse();
            if (tx_req || busy) hits++;
            @(negedge clk);
            if (tx_req || busy) hits++;
        end
        chk(hits == 0, "R4", hits, 0);

        // R3: zero interval fires on the first tick
        start(0);
        chk(tx_req == 1'b0, "R3", int'(tx_req), 0);
        bit_pulse();
        chk(tx_req == 1'b1, "R3", int'(tx_req), 1);
        @(negedge clk);

        // R2: full-range interval 255
        start(255);
        hits = 0;
        for (int i = 0; i < 254; i++) begin
            bit_pulse();
            if (tx_req) hits++;
        end
        chk(hits == 0, "R2", hits, 0);
        chk(busy == 1'b1, "R2", int'(busy), 1);
        bit_pulse();
        chk(tx_req == 1'b1, "R2", int'(tx_req), 1);
        @(negedge clk);

        // R1: reload while running restarts the count
        start(3);
        bit_pulse();
        bit_pulse();
        start(2);
        bit_pulse();
        chk(tx_req == 1'b0, "R1", int'(tx_req), 0);
        bit_pulse();
        chk(tx_req == 1'b1, "R1", int'(tx_req), 1);
        @(negedge clk);

        // R7: select 2'b11 ignores the prescaler
        src_sel = 2'b11;
        start(1);
        hits = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tx_req) hits++;
        end
        chk(hits == 0, "R7", hits, 0);
        bit_pulse();
        chk(tx_req == 1'b1, "R7", int'(tx_req), 1);

        // R6: prescaler x1, m=3 (period 6), all phase offsets
        src_sel = 2'b00;
        pre_trial(0, 2, 6, 1, "R6");
        for (int w = 0; w < 6; w++) pre_trial(w, 2, 6, 2, "R6");
        for (int w = 0; w < 6; w++) pre_trial(w, 0, 6, 2, "R3");
        pre_trial(3, 1, 6, 2, "R6");
        pre_trial(2, 5, 6, 2, "R5");

        // R5: prescaler value 0 acts as 1 (period 2)
        presc_val = 16'd0;
        pre_trial(0, 3, 2, 0, "R5");
        pre_trial(0, 3, 2, 2, "R5");
        pre_trial(1, 3, 2, 2, "R5");
        presc_val = 16'd1;
        pre_trial(1, 4, 2, 2, "R5");

        // R7: divide-by-ten mode, m=1 (period 20)
        src_sel = 2'b10;
        pre_trial(0, 2, 20, 1, "R7");
        pre_trial(0, 2, 20, 2, "R7");
        pre_trial(7, 2, 20, 2, "R7");
        pre_trial(19, 2, 20, 2, "R7");
        presc_val = 16'd2;
        pre_trial(0, 1, 40, 0, "R7");
        pre_trial(5, 1, 40, 2, "R7");

        // R8: reset restarts prescaler and divider; first divided tick
        // follows the tenth wrap, request visible 20 edges after release
        presc_val = 16'd1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && tx_req == 1'b0, "R8", int'(busy), 0);
        rst_n = 1'b1;
        ivl_val = 8'd1;
        tx_done = 1'b1;
        d = 0;
        while (d < 80) begin
            @(negedge clk);
            tx_done = 1'b0;
            d++;
            if (tx_req) break;
        end
        chk(d == 20, "R8", d, 20);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule